// File: doc/BRIEF.md
# Flash Command Sequencer with Error Status

This block sits between a simple byte-wide write bus and the auto-program and auto-erase engine of an on-chip flash controller. Software issues two-cycle commands. A program command is one opcode byte followed by the data byte at the target address. A block-erase command is one opcode byte followed by a confirm byte at an address inside the block. The sequencer checks each sequence before any operation starts. It looks at the global rewrite permission, two further rewrite-disable inputs, the per-block lock bits and the top of the allocated flash map. When every check passes, it starts the engine with a one-cycle strobe and waits for a done pulse that carries a pass or fail flag.

A two-bit error field records the outcome. All kinds of malformed or forbidden sequences share one code. Erase failures and program failures each have a code of their own. A clear-status command resets the field. An FFh byte in either bus cycle returns the controller to read-array mode, abandons any half-entered command and leaves the error field unchanged. The flash array and its engine are outside this block.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `ready` is 1, `err_code` is 00, `read_array` is 1 and `op_start` is 0.
- R2: Writing 40h and then a data byte at an allowed address raises `op_start` for exactly the one cycle after the second write. At that point `op_erase` is 0, and `op_addr` and `op_data` carry the address and data of the second write.
- R3: Writing FFh puts the controller in read-array mode (`read_array` = 1) from the next cycle. In the second cycle of a command it also discards the pending command without starting an operation. It never changes `err_code`.
- R4: Writing 20h and then D0h at an allowed address starts an erase (`op_erase` = 1). Any second byte other than D0h or FFh sets `err_code` to 11 and starts nothing.
- R5: A program or erase second cycle sets `err_code` to 11 and starts nothing in either of these cases: `rewrite_en` is 0, or `rw_dis_a` or `rw_dis_b` is 1.
- R6: A second-cycle address at or above `FLASH_TOP` (default E000h) sets `err_code` to 11 and starts nothing. Address `FLASH_TOP`-1 is accepted.
- R7: A second-cycle address whose block, taken from the top two address bits, has its `blk_lock` bit set gives `err_code` 11 and starts nothing.
- R8: A first-cycle byte other than 40h, 20h, 50h or FFh sets `err_code` to 11.
- R9: When `op_done` arrives with `op_fail` = 1, `err_code` becomes 10 after an erase and 01 after a program. With `op_fail` = 0 it becomes 00.
- R10: `ready` is 0 from the cycle in which `op_start` is high until the cycle after `op_done`. Bus writes made while `ready` is 0 are ignored.
- R11: `err_code` holds its value until a single-cycle 50h write clears it to 00. A started operation overwrites any earlier error with its own outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | 8 | Bus write data |
| rewrite_en | input | 1 | Global rewrite permission |
| rw_dis_a | input | 1 | First extra rewrite disable |
| rw_dis_b | input | 1 | Second extra rewrite disable |
| blk_lock | input | NUM_BLK | Per-block rewrite lock |
| op_start | output | 1 | One-cycle start strobe to the engine |
| op_erase | output | 1 | 1 = erase, 0 = program |
| op_addr | output | ADDR_W | Target address of the operation |
| op_data | output | 8 | Program data byte |
| op_done | input | 1 | Engine completion pulse |
| op_fail | input | 1 | Engine failure flag, valid with op_done |
| ready | output | 1 | 0 while an operation runs |
| err_code | output | 2 | Error field: 11 sequence, 10 erase, 01 program |
| read_array | output | 1 | 1 while reads are routed to the array |

## Verification
The sequences tried are these: a clean program, a clean erase, each of them with a failing engine, an FFh abort in both the first and second cycle, and an erase with a wrong confirm byte. Each rewrite-disable input is raised alone, and the address sits on both sides of the top of the map and in a locked and an unlocked block. Together these cases separate the three error codes from one another and from a silent abort. A clear command and bus writes issued during a busy engine show that the field is cleared only on request, and that writes during an operation neither clear it nor start a new command.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_PROG  = 2'd1,
        ST_WAIT_ERASE = 2'd2,
        ST_BUSY       = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'b00,
        ERR_PROG  = 2'b01,
        ERR_ERASE = 2'b10,
        ERR_SEQ   = 2'b11
    } err_code_t;

    typedef enum logic [2:0] {
        KIND_PROG,
        KIND_ERASE,
        KIND_CLEAR,
        KIND_READ,
        KIND_BAD
    } first_kind_t;

    localparam logic [7:0] OPC_PROG    = 8'h40;
    localparam logic [7:0] OPC_ERASE   = 8'h20;
    localparam logic [7:0] OPC_CLEAR   = 8'h50;
    localparam logic [7:0] OPC_READ    = 8'hFF;
    localparam logic [7:0] OPC_CONFIRM = 8'hD0;

    // Reasons a second cycle may be refused
    typedef struct packed {
        logic protect;   // rewrite globally forbidden
        logic out_map;   // address beyond the allocated flash
        logic locked;    // target block locked
        logic bad_conf;  // erase confirm byte wrong
    } verdict_t;

    function automatic first_kind_t classify(input logic [7:0] b);
        case (b)
            OPC_PROG:  return KIND_PROG;
            OPC_ERASE: return KIND_ERASE;
            OPC_CLEAR: return KIND_CLEAR;
            OPC_READ:  return KIND_READ;
            default:   return KIND_BAD;
        endcase
    endfunction

    function automatic logic refused(input verdict_t v);
        return v.protect | v.out_map | v.locked | v.bad_conf;
    endfunction

    function automatic err_code_t fail_code(input logic is_erase);
        return is_erase ? ERR_ERASE : ERR_PROG;
    endfunction

endpackage

// File: rtl/fcs_first_decode.sv
module fcs_first_decode
    import fcs_pkg::*;
(
    input  logic [7:0]  wdata,
    output first_kind_t kind
);
    always_comb begin
        kind = classify(wdata);
    end
endmodule

// File: rtl/fcs_guard.sv
module fcs_guard
    import fcs_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_BLK   = 4,
    parameter int FLASH_TOP = 'hE000
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         wdata,
    input  logic               is_erase,
    input  logic               rewrite_en,
    input  logic               rw_dis_a,
    input  logic               rw_dis_b,
    input  logic [NUM_BLK-1:0] blk_lock,
    output verdict_t           verdict
);
    localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
    localparam logic [ADDR_W:0] TOP_EXT = (ADDR_W+1)'(FLASH_TOP);

    logic [BLK_W-1:0]   blk_idx;
    logic [NUM_BLK-1:0] lock_hit;

    assign blk_idx = addr[ADDR_W-1 -: BLK_W];

    // One comparator per block, OR-reduced below
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_lock
        assign lock_hit[g] = blk_lock[g] & (blk_idx == BLK_W'(g));
    end

    always_comb begin
        verdict          = '0;
        verdict.protect  = ~rewrite_en | rw_dis_a | rw_dis_b;
        verdict.out_map  = ({1'b0, addr} >= TOP_EXT);
        verdict.locked   = |lock_hit;
        verdict.bad_conf = is_erase & (wdata != OPC_CONFIRM);
    end
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  first_kind_t       kind,
    input  verdict_t          verdict,
    input  logic              op_done,
    input  logic              op_fail,
    output seq_state_t        state,
    output logic              op_start,
    output logic              op_erase,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output err_code_t         err,
    output logic              rd_arr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            err      <= ERR_NONE;
            rd_arr   <= 1'b1;
            op_start <= 1'b0;
            op_erase <= 1'b0;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (bus_we) begin
                        case (kind)
                            KIND_PROG: begin
                                state  <= ST_WAIT_PROG;
                                rd_arr <= 1'b0;
                            end
                            KIND_ERASE: begin
                                state  <= ST_WAIT_ERASE;
                                rd_arr <= 1'b0;
                            end
                            KIND_CLEAR: begin
                                err    <= ERR_NONE;
                                rd_arr <= 1'b0;
                            end
                            KIND_READ: begin
                                rd_arr <= 1'b1;
                            end
                            default: begin
                                err    <= ERR_SEQ;
                                rd_arr <= 1'b0;
                            end
                        endcase
                    end
                end
                ST_WAIT_PROG, ST_WAIT_ERASE: begin
                    if (bus_we) begin
                        if (bus_wdata == OPC_READ) begin
                            state  <= ST_IDLE;
                            rd_arr <= 1'b1;
                        end else if (refused(verdict)) begin
                            state <= ST_IDLE;
                            err   <= ERR_SEQ;
                        end else begin
                            state    <= ST_BUSY;
                            err      <= ERR_NONE;
                            op_start <= 1'b1;
                            op_erase <= (state == ST_WAIT_ERASE);
                            op_addr  <= bus_addr;
                            op_data  <= bus_wdata;
                        end
                    end
                end
                ST_BUSY: begin
                    if (op_done) begin
                        state <= ST_IDLE;
                        err   <= op_fail ? fail_code(op_erase) : ERR_NONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_BLK   = 4,
    parameter int FLASH_TOP = 'hE000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    input  logic               rewrite_en,
    input  logic               rw_dis_a,
    input  logic               rw_dis_b,
    input  logic [NUM_BLK-1:0] blk_lock,
    output logic               op_start,
    output logic               op_erase,
    output logic [ADDR_W-1:0]  op_addr,
    output logic [7:0]         op_data,
    input  logic               op_done,
    input  logic               op_fail,
    output logic               ready,
    output logic [1:0]         err_code,
    output logic               read_array
);
    first_kind_t kind;
    verdict_t    verdict;
    seq_state_t  state;
    err_code_t   err;

    fcs_first_decode u_dec (
        .wdata (bus_wdata),
        .kind  (kind)
    );

    fcs_guard #(
        .ADDR_W    (ADDR_W),
        .NUM_BLK   (NUM_BLK),
        .FLASH_TOP (FLASH_TOP)
    ) u_guard (
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .is_erase   (state == ST_WAIT_ERASE),
        .rewrite_en (rewrite_en),
        .rw_dis_a   (rw_dis_a),
        .rw_dis_b   (rw_dis_b),
        .blk_lock   (blk_lock),
        .verdict    (verdict)
    );

    fcs_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .kind      (kind),
        .verdict   (verdict),
        .op_done   (op_done),
        .op_fail   (op_fail),
        .state     (state),
        .op_start  (op_start),
        .op_erase  (op_erase),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .err       (err),
        .rd_arr    (read_array)
    );

    assign ready    = (state != ST_BUSY);
    assign err_code = err;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int ADDR_W    = 16,
    parameter int NUM_BLK   = 4,
    parameter int FLASH_TOP = 'hE000
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_we,
    input logic [7:0]         bus_wdata,
    input logic               rewrite_en,
    input logic               rw_dis_a,
    input logic               rw_dis_b,
    input logic [NUM_BLK-1:0] blk_lock,
    input logic               op_start,
    input logic               op_erase,
    input logic [ADDR_W-1:0]  op_addr,
    input logic               op_done,
    input logic               op_fail,
    input logic               ready,
    input logic [1:0]         err_code,
    input logic               read_array
);
    localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;

    logic [NUM_BLK-1:0] lock_prev;
    logic               perm_prev;

    always_ff @(posedge clk) begin
        lock_prev <= blk_lock;
        perm_prev <= rewrite_en & ~rw_dis_a & ~rw_dis_b;
    end

    assert_start_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        op_start |=> !op_start);

    assert_busy_on_start_R10: assert property (@(posedge clk) disable iff (rst)
        op_start |-> !ready);

    assert_ready_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        (!ready && op_done) |=> ready);

    assert_start_permitted_R5: assert property (@(posedge clk) disable iff (rst)
        op_start |-> perm_prev);

    assert_start_in_map_R6: assert property (@(posedge clk) disable iff (rst)
        op_start |-> ({1'b0, op_addr} < (ADDR_W+1)'(FLASH_TOP)));

    assert_start_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
        op_start |-> !lock_prev[op_addr[ADDR_W-1 -: BLK_W]]);

    assert_fail_code_R9: assert property (@(posedge clk) disable iff (rst)
        (!ready && op_done && op_fail) |=> (err_code == (op_erase ? 2'b10 : 2'b01)));

    assert_abort_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && ready && bus_wdata == 8'hFF) |=> (!op_start && read_array && $stable(err_code)));
endmodule

bind flash_cmd_seq fcs_checker #(
    .ADDR_W    (ADDR_W),
    .NUM_BLK   (NUM_BLK),
    .FLASH_TOP (FLASH_TOP)
) u_fcs_checker (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .rewrite_en (rewrite_en),
    .rw_dis_a   (rw_dis_a),
    .rw_dis_b   (rw_dis_b),
    .blk_lock   (blk_lock),
    .op_start   (op_start),
    .op_erase   (op_erase),
    .op_addr    (op_addr),
    .op_done    (op_done),
    .op_fail    (op_fail),
    .ready      (ready),
    .err_code   (err_code),
    .read_array (read_array)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        rewrite_en = 1'b1;
    logic        rw_dis_a = 1'b0;
    logic        rw_dis_b = 1'b0;
    logic [3:0]  blk_lock = '0;
    logic        op_start, op_erase;
    logic [15:0] op_addr;
    logic [7:0]  op_data;
    logic        op_done = 1'b0;
    logic        op_fail = 1'b0;
    logic        ready, read_array;
    logic [1:0]  err_code;

    int vectors = 0;
    int miscompares = 0;
    bit stub_fail = 1'b0;
    int stub_cnt = 0;
    bit seen_start = 1'b0;
    bit        last_erase;
    logic [15:0] last_addr;
    logic [7:0]  last_data;

    always #4 clk = ~clk;   // 125 MHz

    flash_cmd_seq uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rewrite_en(rewrite_en), .rw_dis_a(rw_dis_a),
        .rw_dis_b(rw_dis_b), .blk_lock(blk_lock), .op_start(op_start),
        .op_erase(op_erase), .op_addr(op_addr), .op_data(op_data),
        .op_done(op_done), .op_fail(op_fail), .ready(ready),
        .err_code(err_code), .read_array(read_array)
    );

    // Behavioural reference model
    int   m_st;        // 0 idle, 1 program pending, 2 erase pending, 3 running
    bit [1:0] m_err;
    bit   m_ra, m_start, m_erase;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_err = 0; m_ra = 1; m_start = 0; m_erase = 0;
        end else begin
            m_start = 0;
            if (m_st == 3) begin
                if (op_done) begin
                    m_err = op_fail ? (m_erase ? 2'd2 : 2'd1) : 2'd0;
                    m_st = 0;
                end
            end else if (bus_we && m_st == 0) begin
                m_ra = 0;
                if (bus_wdata == 8'h40) m_st = 1;
                else if (bus_wdata == 8'h20) m_st = 2;
                else if (bus_wdata == 8'h50) m_err = 0;
                else if (bus_wdata == 8'hFF) m_ra = 1;
                else m_err = 3;
            end else if (bus_we) begin
                if (bus_wdata == 8'hFF) begin
                    m_st = 0; m_ra = 1;
                end else if (!rewrite_en || rw_dis_a || rw_dis_b ||
                             bus_addr >= 16'hE000 || blk_lock[bus_addr[15:14]] ||
                             (m_st == 2 && bus_wdata != 8'hD0)) begin
                    m_err = 3; m_st = 0;
                end else begin
                    m_erase = (m_st == 2); m_start = 1; m_err = 0; m_st = 3;
                end
            end
        end
    end

    // Engine stub
    always @(negedge clk) begin
        if (rst) begin
            stub_cnt = 0; op_done = 0;
        end else begin
            op_done = 0;
            if (op_start) begin
                stub_cnt = LAT; seen_start = 1;
                last_erase = op_erase; last_addr = op_addr; last_data = op_data;
            end else if (stub_cnt > 0) begin
                stub_cnt--;
                if (stub_cnt == 0) begin
                    op_done = 1; op_fail = stub_fail;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison with the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(ready == (m_st != 3), "R10 ready", ready, m_st != 3);
            chk(err_code == m_err, "R11 err_code", err_code, m_err);
            chk(read_array == m_ra, "R3 read_array", read_array, m_ra);
            chk(op_start == m_start, "R2 op_start", op_start, m_start);
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(ready && err_code == 0 && read_array && !op_start, "R1 reset state",
            {ready, err_code, read_array, op_start}, 5'b10010);

        // R2 clean program
        seen_start = 0;
        wr(16'h1234, 8'h40); wr(16'h1234, 8'h5A);
        chk(!ready, "R10 busy after start", ready, 0);
        wait_ready();
        chk(seen_start && !last_erase && last_addr == 16'h1234 && last_data == 8'h5A,
            "R2 program request", last_addr, 16'h1234);
        chk(err_code == 2'b00, "R9 program pass", err_code, 0);

        // R9 program failure
        stub_fail = 1;
        wr(16'h0100, 8'h40); wr(16'h0100, 8'h00);
        wait_ready();
        chk(err_code == 2'b01, "R9 program fail", err_code, 1);

        // R11 clear
        wr(16'h0000, 8'h50);
        chk(err_code == 2'b00, "R11 clear", err_code, 0);

        // R4 erase failure
        seen_start = 0;
        wr(16'h4000, 8'h20); wr(16'h4000, 8'hD0);
        wait_ready();
        chk(seen_start && last_erase, "R4 erase start", last_erase, 1);
        chk(err_code == 2'b10, "R9 erase fail", err_code, 2);

        // R11 new operation overwrites
        stub_fail = 0;
        wr(16'h0200, 8'h40); wr(16'h0200, 8'h11);
        wait_ready();
        chk(err_code == 2'b00, "R11 overwrite", err_code, 0);

        // R4 bad confirm
        seen_start = 0;
        wr(16'h4000, 8'h20); wr(16'h4000, 8'h33);
        chk(err_code == 2'b11 && !seen_start, "R4 bad confirm", err_code, 3);

        // R3 second-cycle abort keeps error
        wr(16'h0000, 8'h40); wr(16'h0000, 8'hFF);
        chk(err_code == 2'b11 && read_array && !seen_start, "R3 abort keeps err", err_code, 3);
        wr(16'h0000, 8'h50);
        wr(16'h4000, 8'h20); wr(16'h4000, 8'hFF);
        chk(err_code == 2'b00 && read_array, "R3 erase abort quiet", err_code, 0);

        // R8 unknown opcode
        wr(16'h0000, 8'h77);
        chk(err_code == 2'b11, "R8 unknown opcode", err_code, 3);
        wr(16'h0000, 8'hFF);
        chk(read_array && err_code == 2'b11, "R3 first-cycle FF", read_array, 1);

        // R5 protection inputs, one at a time
        for (int k = 0; k < 3; k++) begin
            wr(16'h0000, 8'h50);
            rewrite_en = (k != 0); rw_dis_a = (k == 1); rw_dis_b = (k == 2);
            wr(16'h0300, 8'h40); wr(16'h0300, 8'h22);
            chk(err_code == 2'b11 && ready, "R5 rewrite disabled", err_code, 3);
        end
        rewrite_en = 1; rw_dis_a = 0; rw_dis_b = 0;

        // R6 map boundary
        wr(16'h0000, 8'h50);
        wr(16'hE000, 8'h40); wr(16'hE000, 8'h01);
        chk(err_code == 2'b11, "R6 above top", err_code, 3);
        seen_start = 0;
        wr(16'hDFFF, 8'h40); wr(16'hDFFF, 8'h02);
        wait_ready();
        chk(seen_start && err_code == 2'b00, "R6 last allocated", err_code, 0);

        // R7 locks
        blk_lock = 4'b0100;
        wr(16'h8000, 8'h20); wr(16'h8000, 8'hD0);
        chk(err_code == 2'b11, "R7 locked block", err_code, 3);
        seen_start = 0;
        wr(16'h4000, 8'h20); wr(16'h4000, 8'hD0);
        wait_ready();
        chk(seen_start && err_code == 2'b00, "R7 unlocked block", err_code, 0);
        blk_lock = 0;

        // R10 writes during busy are ignored
        stub_fail = 1;
        wr(16'h0400, 8'h40); wr(16'h0400, 8'h03);
        wr(16'h0000, 8'h50);
        wr(16'h0000, 8'h77);
        wait_ready();
        chk(err_code == 2'b01, "R10 busy writes ignored", err_code, 1);
        stub_fail = 0;

        repeat (4) @(negedge clk);
        summary();
    end
endmodule